// File: doc/BRIEF.md
# Rope memory drive-line sequencer

This block sits between a fixed-memory read request and the drivers of one woven-core read-only module. A start strobe captures a 9-bit word address. The block then runs a timed sequence of phases. In the first phase it switches exactly one core. It does this by driving one of two layer-wide set lines, one line from each of seven binary inhibit pairs, and one line of a parity inhibit pair. It also drives the reset line of the neighbouring plane in the same layer, so that cores no inhibit wire covers cannot switch. In the second phase it drives only the reset line of the addressed plane and enables the sense strands.

Every line is dropped for a programmable number of idle cycles between the two phases. If the requester aborts during that gap, the block drives a clear line instead of the second phase. A one-cycle done pulse closes either path.

Address bit k (k = 1..9) is `addr_i[k-1]`. The addressed plane index is {bit 9, bit 8}: 0 is A, 1 is B, 2 is C and 3 is D. Plane p drives `reset_o[p]`.

Top module: `rope_drive_seq`

## Requirements
- R1: After reset every drive line is low, and `strand_en_o`, `clear_o`, `done_o` and `busy_o` are low.
- R2: During the set phase, for each address bit k in 1..7, `inh_o[k-1]` equals bit k and `inh_n_o[k-1]` equals its complement. Both vectors are zero in every other phase.
- R3: During the set phase, `set_ab_o` is high when bit 9 is 0 and `set_cd_o` is high when bit 9 is 1. Neither is high outside the set phase.
- R4: During the set phase, `par_inh_o` is high when address bits 1..8 contain an even number of ones, and `par_inh_n_o` is high when the count is odd.
- R5: During the set phase, exactly one reset line is high. It is the line of the other plane in the same layer, `reset_o[{bit9, ~bit8}]`.
- R6: During the reset phase, only `reset_o[{bit9, bit8}]` and `strand_en_o` are high. No set, inhibit or clear line is high.
- R7: An abort that is high on any clock edge of the inter-phase gap replaces the reset phase with a clear phase of CLR_CYC cycles. In the clear phase only `clear_o` is high, and no reset line or strand enable is driven.
- R8: The set phase lasts SET_CYC cycles, beginning on the edge that samples start in idle. The gap lasts GAP_CYC (≥1) cycles with every line low. The reset phase lasts RST_CYC cycles.
- R9: `done_o` is high for exactly one cycle, in the cycle right after the reset or clear phase. The block is idle in the cycle after that.
- R10: The address is captured only when start is accepted. Changes on `addr_i`, and start pulses while `busy_o` is high, have no effect on the running sequence.
- R11: Abort has no effect when it is sampled in the set phase, the reset phase, the done cycle or idle.
- R12: `busy_o` is high from the first set-phase cycle through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, accepted in idle |
| abort_i | input | 1 | Abort request, effective during the gap |
| addr_i | input | 9 | Word address within the module |
| busy_o | output | 1 | Sequence in progress |
| set_ab_o | output | 1 | Set line for planes A/B |
| set_cd_o | output | 1 | Set line for planes C/D |
| reset_o | output | 4 | Per-plane reset lines, index = plane |
| inh_o | output | 7 | True inhibit lines for address bits 1..7 |
| inh_n_o | output | 7 | Complement inhibit lines for address bits 1..7 |
| par_inh_o | output | 1 | Parity inhibit, even ones count |
| par_inh_n_o | output | 1 | Parity inhibit, odd ones count |
| strand_en_o | output | 1 | Sense strand enable |
| clear_o | output | 1 | Clear line for aborted cycles |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after the corner cases of the line selection and of the phase timing.

The first corner case is the plane boundary. Addresses whose bit 8 differs, such as 0x07F and 0x080, catch a design that picks the wrong neighbour reset line or drives the target plane during set. Addresses with all ones and all zeros in the low byte expose a parity sense that is inverted.

Aborts are placed on the first and last gap cycle and also inside the set and reset phases. A design that checks abort in the wrong phase would either skip the clear line or cut short a good read.

Address changes and repeated start strobes during a cycle would show up as shifted inhibit patterns or a restarted sequence in a design that does not latch its inputs.

// File: rtl/rope_seq_pkg.sv
package rope_seq_pkg;
  localparam int ADDR_W  = 9;
  localparam int INH_W   = ADDR_W - 2;
  localparam int PLANE_N = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SET,
    PH_GAP,
    PH_RST,
    PH_CLR,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/rope_phase_ctrl.sv
module rope_phase_ctrl
  import rope_seq_pkg::*;
#(
  parameter int SET_CYC = 4,
  parameter int GAP_CYC = 1,
  parameter int RST_CYC = 4,
  parameter int CLR_CYC = 2,
  parameter int CNT_W   = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   abort_i,
  output phase_e phase_o,
  output logic   load_en_o
);
  phase_e             state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               abort_q, abort_d;
  logic               cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    abort_d   = abort_q;
    load_en_o = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        abort_d = 1'b0;
        if (start_i) begin
          load_en_o = 1'b1;
          state_d   = PH_SET;
          cnt_d     = CNT_W'(SET_CYC - 1);
        end
      end
      PH_SET: begin
        if (cnt_zero) begin
          state_d = PH_GAP;
          cnt_d   = CNT_W'(GAP_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_GAP: begin
        abort_d = abort_q | abort_i;
        if (cnt_zero) begin
          if (abort_d) begin
            state_d = PH_CLR;
            cnt_d   = CNT_W'(CLR_CYC - 1);
          end else begin
            state_d = PH_RST;
            cnt_d   = CNT_W'(RST_CYC - 1);
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_RST, PH_CLR: begin
        if (cnt_zero) state_d = PH_DONE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      PH_DONE: state_d = PH_IDLE;
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      abort_q <= abort_d;
    end
  end

  assign phase_o = state_q;

  // R7: a gap that ends with abort seen goes to the clear phase
  a_r7_abort_to_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_GAP && cnt_zero && abort_i) |=> (state_q == PH_CLR));

  // R9: the done cycle is always followed by idle
  a_r9_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_DONE) |=> (state_q == PH_IDLE));

  // R11: abort in the set phase never diverts the sequence
  a_r11_set_abort_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_SET) |=> (state_q == PH_SET || state_q == PH_GAP));
endmodule

// File: rtl/rope_line_decode.sv
module rope_line_decode
  import rope_seq_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr_i,
  input  phase_e             phase_i,
  output logic               set_ab_o,
  output logic               set_cd_o,
  output logic [PLANE_N-1:0] reset_o,
  output logic [INH_W-1:0]   inh_o,
  output logic [INH_W-1:0]   inh_n_o,
  output logic               par_inh_o,
  output logic               par_inh_n_o,
  output logic               strand_en_o,
  output logic               clear_o,
  output logic               done_o,
  output logic               busy_o
);
  logic       in_set;
  logic       odd_ones;
  logic [1:0] tgt_plane;
  logic [1:0] nbr_plane;

  assign in_set    = (phase_i == PH_SET);
  assign odd_ones  = ^addr_i[ADDR_W-2:0];
  assign tgt_plane = addr_i[ADDR_W-1:ADDR_W-2];
  assign nbr_plane = {addr_i[ADDR_W-1], ~addr_i[ADDR_W-2]};

  always_comb begin
    set_ab_o    = in_set & ~addr_i[ADDR_W-1];
    set_cd_o    = in_set &  addr_i[ADDR_W-1];
    inh_o       = in_set ? addr_i[INH_W-1:0]  : '0;
    inh_n_o     = in_set ? ~addr_i[INH_W-1:0] : '0;
    par_inh_o   = in_set & ~odd_ones;
    par_inh_n_o = in_set &  odd_ones;
    strand_en_o = (phase_i == PH_RST);
    clear_o     = (phase_i == PH_CLR);
    done_o      = (phase_i == PH_DONE);
    busy_o      = (phase_i != PH_IDLE);
    reset_o     = '0;
    for (int p = 0; p < PLANE_N; p++) begin
      if (in_set && nbr_plane == 2'(p))             reset_o[p] = 1'b1;
      if (phase_i == PH_RST && tgt_plane == 2'(p))  reset_o[p] = 1'b1;
    end
  end
endmodule

// File: rtl/rope_drive_seq.sv
module rope_drive_seq
  import rope_seq_pkg::*;
#(
  parameter int SET_CYC = 4,
  parameter int GAP_CYC = 1,
  parameter int RST_CYC = 4,
  parameter int CLR_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        abort_i,
  input  logic [8:0]  addr_i,
  output logic        busy_o,
  output logic        set_ab_o,
  output logic        set_cd_o,
  output logic [3:0]  reset_o,
  output logic [6:0]  inh_o,
  output logic [6:0]  inh_n_o,
  output logic        par_inh_o,
  output logic        par_inh_n_o,
  output logic        strand_en_o,
  output logic        clear_o,
  output logic        done_o
);
  localparam int MAX_AB = (SET_CYC > GAP_CYC) ? SET_CYC : GAP_CYC;
  localparam int MAX_CD = (RST_CYC > CLR_CYC) ? RST_CYC : CLR_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAXC + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  phase_e            phase;
  logic              load_en;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  rope_phase_ctrl #(
    .SET_CYC (SET_CYC),
    .GAP_CYC (GAP_CYC),
    .RST_CYC (RST_CYC),
    .CLR_CYC (CLR_CYC),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start_i   (start_i),
    .abort_i   (abort_i),
    .phase_o   (phase),
    .load_en_o (load_en)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     addr_q <= '0;
    else if (load_en) addr_q <= addr_i;
  end

  rope_line_decode u_dec (
    .addr_i      (addr_q),
    .phase_i     (phase),
    .set_ab_o    (set_ab_o),
    .set_cd_o    (set_cd_o),
    .reset_o     (reset_o),
    .inh_o       (inh_o),
    .inh_n_o     (inh_n_o),
    .par_inh_o   (par_inh_o),
    .par_inh_n_o (par_inh_n_o),
    .strand_en_o (strand_en_o),
    .clear_o     (clear_o),
    .done_o      (done_o),
    .busy_o      (busy_o)
  );

  // R5: never more than one reset line at a time
  a_r5_reset_onehot: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(reset_o));

  // R3: the two set lines are exclusive
  a_r3_set_exclusive: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(set_ab_o && set_cd_o));

  // R2: inhibit pairs are complementary whenever a set line is up
  a_r2_inh_pairs: assert property (@(posedge clk) disable iff (!rst_n_s)
    (set_ab_o || set_cd_o) |-> ((inh_o ^ inh_n_o) == '1 && (par_inh_o ^ par_inh_n_o)));

  // R6: strand enable never overlaps set or inhibit drive
  a_r6_strand_clean: assert property (@(posedge clk) disable iff (!rst_n_s)
    strand_en_o |-> (!set_ab_o && !set_cd_o && inh_o == '0 && inh_n_o == '0
                     && !par_inh_o && !par_inh_n_o && !clear_o && $countones(reset_o) == 1));

  // R7: clear never overlaps reset drive or strand enable
  a_r7_clear_clean: assert property (@(posedge clk) disable iff (!rst_n_s)
    clear_o |-> (reset_o == '0 && !strand_en_o));

  // R8: the cycle after set drive ends has every line low
  a_r8_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(set_ab_o || set_cd_o) |-> (reset_o == '0 && !strand_en_o && !clear_o && inh_o == '0));

  // R9: done is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |=> !done_o);

  // R10: latched address holds while a sequence runs
  a_r10_addr_held: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy_o && $past(busy_o)) |-> $stable(addr_q));
endmodule

// File: tb/tb_rope_drive_seq.sv
module tb_rope_drive_seq;
  localparam int CLK_PERIOD = 10;
  localparam int S = 3;
  localparam int G = 2;
  localparam int R = 4;
  localparam int C = 2;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic       abort_i;
  logic [8:0] addr_i;
  logic       busy_o, set_ab_o, set_cd_o, par_inh_o, par_inh_n_o;
  logic       strand_en_o, clear_o, done_o;
  logic [3:0] reset_o;
  logic [6:0] inh_o, inh_n_o;

  int n_chk;
  int n_bad;
  bit finished;

  rope_drive_seq #(.SET_CYC(S), .GAP_CYC(G), .RST_CYC(R), .CLR_CYC(C)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i), .addr_i(addr_i),
    .busy_o(busy_o), .set_ab_o(set_ab_o), .set_cd_o(set_cd_o), .reset_o(reset_o),
    .inh_o(inh_o), .inh_n_o(inh_n_o), .par_inh_o(par_inh_o), .par_inh_n_o(par_inh_n_o),
    .strand_en_o(strand_en_o), .clear_o(clear_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // bit order: set_ab set_cd reset[3:0] inh[6:0] inh_n[6:0] par par_n strand clear done busy
  function automatic logic [25:0] outv();
    return {set_ab_o, set_cd_o, reset_o, inh_o, inh_n_o, par_inh_o, par_inh_n_o,
            strand_en_o, clear_o, done_o, busy_o};
  endfunction

  // ph: 0 idle, 1 set, 2 gap, 3 reset, 4 clear, 5 done
  function automatic logic [25:0] expv(input logic [8:0] a, input int ph);
    logic sab, scd, par, parn, str, clr, dn, bsy;
    logic [3:0] rs;
    logic [6:0] ih, ihn;
    int ones;
    sab = 0; scd = 0; par = 0; parn = 0; str = 0; clr = 0; dn = 0;
    rs = 0; ih = 0; ihn = 0;
    bsy = (ph != 0);
    if (ph == 1) begin
      sab = !a[8];
      scd = a[8];
      ih  = a[6:0];
      ihn = ~a[6:0];
      ones = 0;
      for (int i = 0; i < 8; i++) ones += a[i];
      par  = (ones % 2 == 0);
      parn = !par;
      rs[a[8]*2 + (a[7] ? 0 : 1)] = 1'b1;
    end else if (ph == 3) begin
      rs[a[8]*2 + a[7]] = 1'b1;
      str = 1;
    end else if (ph == 4) begin
      clr = 1;
    end else if (ph == 5) begin
      dn = 1;
    end
    return {sab, scd, rs, ih, ihn, par, parn, str, clr, dn, bsy};
  endfunction

  task automatic check(input logic [25:0] act, input logic [25:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string ph_tag(input int ph);
    case (ph)
      1: return "R2 R3 R4 R5 set phase";
      2: return "R8 gap";
      3: return "R6 reset phase";
      4: return "R7 clear phase";
      5: return "R9 done";
      default: return "R9 idle after done";
    endcase
  endfunction

  // runs one request; abort driven on the negedge of cycle abort_k (-1 none)
  task automatic run_seq(input logic [8:0] a, input int abort_k, input bit noise);
    bit clr_path;
    int last_len, total, ph;
    clr_path = (abort_k >= S) && (abort_k < S + G);
    last_len = clr_path ? C : R;
    total    = S + G + last_len + 2;
    start_i = 1'b1;
    addr_i  = a;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < total; k++) begin
      if (k < S)                        ph = 1;
      else if (k < S + G)               ph = 2;
      else if (k < S + G + last_len)    ph = clr_path ? 4 : 3;
      else if (k == S + G + last_len)   ph = 5;
      else                              ph = 0;
      check(outv(), expv(a, ph), ph_tag(ph));
      if (k == 0) check({31'd0, busy_o}, 32'd1, "R12 busy in first set cycle");
      abort_i = (k == abort_k);
      if (noise && k < total - 1) begin
        addr_i  = a ^ 9'(k * 37 + 1);
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    abort_i = 1'b0;
    start_i = 1'b0;
  endtask

  task automatic t_reset();
    check(outv(), 26'd0, "R1 reset state");
  endtask

  task automatic t_plain();
    run_seq(9'h000, -1, 1'b0);
    run_seq(9'h1FF, -1, 1'b0);
    run_seq(9'h0A5, -1, 1'b0);
    run_seq(9'h07F, -1, 1'b0);
    run_seq(9'h080, -1, 1'b0);
    run_seq(9'h13C, -1, 1'b0);
  endtask

  task automatic t_abort_gap();
    run_seq(9'h055, S, 1'b0);
    run_seq(9'h1C3, S + G - 1, 1'b0);
  endtask

  task automatic t_abort_ignored();
    run_seq(9'h0F0, 0, 1'b0);
    run_seq(9'h10F, S - 1, 1'b0);
    run_seq(9'h0C1, S + G, 1'b0);
    run_seq(9'h1AA, S + G + R, 1'b0);
    check(outv(), 26'd0, "R11 idle after ignored abort");
  endtask

  task automatic t_addr_noise();
    run_seq(9'h0B6, -1, 1'b1);
    run_seq(9'h16D, S, 1'b1);
    check(outv(), 26'd0, "R10 idle after noisy inputs");
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 0;
    rst_n = 1'b0; start_i = 1'b0; abort_i = 1'b0; addr_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_plain();
    t_abort_gap();
    t_abort_ignored();
    t_addr_noise();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule